// File: doc/BRIEF.md
# Zero-Cross Gated Volume and Mute Controller

This block holds the attenuation and mute setting in force on each of six audio output channels. New settings arrive as per-channel write strobes. A new setting is not put into use at once. It waits until that channel's sample stream crosses zero, so the level step makes no audible click. A channel whose signal never crosses zero still gets its new setting: the change is forced after a bounded number of frames. A bypass control makes every change take effect at once.

Each channel shows a pending flag from the write until the new setting is in use. Software can poll this flag to see that a volume change has landed. A separate silence detector mutes every output after a long run of frames in which all six channels carry only 0 or -1. The first frame with real signal on any channel releases that mute. The block only decides which setting is active. The gain arithmetic and the analog stages sit downstream.

Top module: `zc_vol_ctrl`

## Requirements
- R1: While a change is pending on a channel, it is applied on a frame strobe where that channel's sample is exactly zero or has a sign bit different from the previous frame's sample. The previous sign is taken as positive after reset. The active value changes on the clock edge that samples that strobe.
- R2: `accept[i]` is high from the clock edge after a write to channel i (with bypass off) until the edge on which the pending setting becomes active.
- R3: A 9-bit frame counter runs freely from reset and marks a tick on every strobe at which it holds 511. A pending change that sees no crossing is forced on the second tick after the write, which is 512 to 1024 frames later. A tick in the cycle of the write itself is not counted.
- R4: A write to a channel that already has a change pending replaces the pending attenuation and mute values. It does not restart the timeout. If the write and an applying event fall in the same cycle, the write wins and the change stays pending.
- R5: When `zc_disable` is 1, a write becomes active on the next edge, and `accept` stays low. Any change already pending is applied on the first edge while `zc_disable` is 1.
- R6: Mute requests (`req_mute`, where 1 means muted) are held and applied together with the attenuation, under the same crossing, timeout and bypass rules.
- R7: With `automute_en` at 1, `auto_mute` and every bit of `out_mute` go high on the strobe of the 512th consecutive frame in which all six samples are 0 or all-ones (-1).
- R8: A strobe with any other sample value on any channel clears `auto_mute` and restarts the run count. With `automute_en` at 0, `auto_mute` is 0.
- R9: Attenuation is in 1 dB steps, where code n means n dB. A requested code above 85 is held as 85.
- R10: After reset, all active attenuations are 0, and all mute, accept and auto-mute outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking a new frame of samples |
| samples | input | 120 | Six signed 20-bit samples; channel i at bits [20i+19:20i] |
| req_wr | input | 6 | Per-channel write strobe for a new setting |
| req_att | input | 42 | Requested attenuation codes, 7 bits per channel |
| req_mute | input | 6 | Requested mute per channel |
| zc_disable | input | 1 | 1 makes changes take effect immediately |
| automute_en | input | 1 | 1 enables the silence auto-mute |
| act_att | output | 42 | Active attenuation, 7 bits per channel |
| act_mute | output | 6 | Active requested mute per channel |
| accept | output | 6 | Change pending on the channel |
| out_mute | output | 6 | Effective mute: channel mute or auto-mute |
| auto_mute | output | 1 | Silence auto-mute in force |

## Verification
A constant positive stream never crosses zero, so it isolates the timeout path. An alternating-sign stream applies changes on the very next strobe, which shows that the crossing path is independent of the tick. A second write part-way through a timeout shows that the value is replaced while the deadline is kept. Mixed 0 and -1 streams drive the silence counter, and a single non-silent frame afterwards checks the release, with the enable both set and cleared. A behavioural model in the bench predicts every output on every clock.

// File: rtl/zc_pkg.sv
// Package: shared widths and the setting record used by the volume controller.
// Assumes six-channel operation is the common case; widths are overridable
// at the top through parameters that must agree with these defaults.
package zc_pkg;
    localparam int ATT_W     = 7;
    localparam int ATT_MAX   = 85;
    localparam int TICK_W    = 9;

    // One channel's setting: attenuation code and mute.
    typedef struct packed {
        logic [ATT_W-1:0] att;
        logic             mute;
    } zc_setting_t;
endpackage

// File: rtl/zc_frame_timer.sv
// Module: free-running frame counter producing a tick every 2**TICK_W frames.
// Assumes frame_stb is a single-cycle pulse. The tick is combinational and
// coincides with the strobe at which the counter holds its top value.
module zc_frame_timer #(
    parameter int TICK_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    output logic tick
);
    localparam logic [TICK_W-1:0] TOP = {TICK_W{1'b1}};

    logic [TICK_W-1:0] cnt;

    // Tick on the strobe that wraps the counter.
    always_comb tick = frame_stb && (cnt == TOP);

    // Count frames from reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (frame_stb) cnt <= cnt + 1'b1;
    end

    AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0)); // R3
endmodule

// File: rtl/zc_silence_det.sv
// Module: detects a long run of frames where every channel carries 0 or -1.
// Assumes samples are presented together and qualified by frame_stb.
// Raises the mute on the strobe of the LIMIT-th silent frame; any other
// frame clears it at once.
module zc_silence_det #(
    parameter int NCH   = 6,
    parameter int SMP_W = 20,
    parameter int LIMIT = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic [NCH*SMP_W-1:0] samples,
    input  logic                 enable,
    output logic                 auto_mute
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic          silent;
    logic [CW-1:0] run_cnt;
    logic          mute_q;

    // Frame is silent when each channel is all zeros or all ones.
    always_comb begin
        silent = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (!((samples[i*SMP_W +: SMP_W] == '0) ||
                  (samples[i*SMP_W +: SMP_W] == {SMP_W{1'b1}})))
                silent = 1'b0;
        end
    end

    // Count silent frames, saturate at the limit, clear on signal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            mute_q  <= 1'b0;
        end else if (frame_stb) begin
            if (!silent) begin
                run_cnt <= '0;
                mute_q  <= 1'b0;
            end else if (run_cnt == LAST) begin
                mute_q  <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Enable gates the output only.
    always_comb auto_mute = mute_q && enable;

    AST_SIGNAL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !silent) |=> !auto_mute); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !auto_mute); // R8
endmodule

// File: rtl/zc_chan_ctrl.sv
// Module: one channel's pending-setting logic. Holds a requested setting
// until a zero crossing, a second timer tick, or the bypass applies it.
// Assumes tick and frame_stb come from the shared frame timer and strobe.
module zc_chan_ctrl
    import zc_pkg::*;
#(
    parameter int SMP_W   = 20,
    parameter int ATT_MAX = zc_pkg::ATT_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [SMP_W-1:0] sample,
    input  logic             tick,
    input  logic             wr,
    input  logic [ATT_W-1:0] req_att,
    input  logic             req_mute,
    input  logic             zc_dis,
    output logic [ATT_W-1:0] act_att,
    output logic             act_mute,
    output logic             pend
);
    localparam logic [ATT_W-1:0] CAP = ATT_W'(ATT_MAX);

    zc_setting_t active_q, pend_q, req_s;
    logic        prev_neg;
    logic        tick_seen;
    logic        zc;
    logic        apply;

    // Saturate the requested code.
    always_comb begin
        req_s.att  = (req_att > CAP) ? CAP : req_att;
        req_s.mute = req_mute;
    end

    // Crossing: exact zero or sign flip on a frame strobe.
    always_comb zc = frame_stb &&
                     ((sample == '0) || (sample[SMP_W-1] != prev_neg));

    // Pending setting becomes active on any applying event.
    always_comb apply = pend && (zc_dis || zc || (tick && tick_seen));

    // Remember sign of the last frame's sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_neg <= 1'b0;
        else if (frame_stb) prev_neg <= sample[SMP_W-1];
    end

    // Accept writes, apply pending settings, track timeout ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= '0;
            pend_q    <= '0;
            pend      <= 1'b0;
            tick_seen <= 1'b0;
        end else if (wr) begin
            pend_q <= req_s;
            if (zc_dis) begin
                active_q  <= req_s;
                pend      <= 1'b0;
                tick_seen <= 1'b0;
            end else begin
                pend      <= 1'b1;
                tick_seen <= pend && (tick_seen || tick);
            end
        end else if (apply) begin
            active_q  <= pend_q;
            pend      <= 1'b0;
            tick_seen <= 1'b0;
        end else if (pend && tick) begin
            tick_seen <= 1'b1;
        end
    end

    always_comb begin
        act_att  = active_q.att;
        act_mute = active_q.mute;
    end

    AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !zc_dis) |=> pend); // R2
    AST_BYPASS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && zc_dis) |=> !pend); // R5
    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !frame_stb && !zc_dis) |=> ($stable(act_att) && $stable(act_mute))); // R1
    AST_ATT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_att <= CAP); // R9
endmodule

// File: rtl/zc_vol_ctrl.sv
// Module: six-channel zero-cross gated attenuation and mute controller.
// Assumes samples and frame_stb are synchronous to clk and that writes are
// single-cycle strobes per channel. Combines per-channel pending logic, a
// shared frame timer and a silence auto-mute.
module zc_vol_ctrl #(
    parameter int NCH     = 6,
    parameter int SMP_W   = 20,
    parameter int ATT_W   = zc_pkg::ATT_W,
    parameter int ATT_MAX = zc_pkg::ATT_MAX,
    parameter int TICK_W  = zc_pkg::TICK_W,
    parameter int SIL_LEN = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic [NCH*SMP_W-1:0] samples,
    input  logic [NCH-1:0]       req_wr,
    input  logic [NCH*ATT_W-1:0] req_att,
    input  logic [NCH-1:0]       req_mute,
    input  logic                 zc_disable,
    input  logic                 automute_en,
    output logic [NCH*ATT_W-1:0] act_att,
    output logic [NCH-1:0]       act_mute,
    output logic [NCH-1:0]       accept,
    output logic [NCH-1:0]       out_mute,
    output logic                 auto_mute
);
    logic tick;

    zc_frame_timer #(.TICK_W(TICK_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .tick      (tick)
    );

    zc_silence_det #(.NCH(NCH), .SMP_W(SMP_W), .LIMIT(SIL_LEN)) u_silence (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .samples   (samples),
        .enable    (automute_en),
        .auto_mute (auto_mute)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        zc_chan_ctrl #(.SMP_W(SMP_W), .ATT_MAX(ATT_MAX)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_stb (frame_stb),
            .sample    (samples[g*SMP_W +: SMP_W]),
            .tick      (tick),
            .wr        (req_wr[g]),
            .req_att   (req_att[g*ATT_W +: ATT_W]),
            .req_mute  (req_mute[g]),
            .zc_dis    (zc_disable),
            .act_att   (act_att[g*ATT_W +: ATT_W]),
            .act_mute  (act_mute[g]),
            .pend      (accept[g])
        );
    end

    // Auto-mute silences every output on top of each channel's own mute.
    always_comb out_mute = act_mute | {NCH{auto_mute}};

    AST_AUTO_MUTES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mute |-> (&out_mute)); // R7
endmodule

// File: tb/tb_zc_vol_ctrl.sv
`timescale 1ns/1ps
module tb_zc_vol_ctrl;
    localparam int NCH = 6;
    localparam int SW  = 20;
    localparam int AW  = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                frame_stb = 1'b0;
    logic [NCH*SW-1:0]   samples = '0;
    logic [NCH-1:0]      req_wr = '0;
    logic [NCH*AW-1:0]   req_att = '0;
    logic [NCH-1:0]      req_mute = '0;
    logic                zc_disable = 1'b0;
    logic                automute_en = 1'b0;
    logic [NCH*AW-1:0]   act_att;
    logic [NCH-1:0]      act_mute;
    logic [NCH-1:0]      accept;
    logic [NCH-1:0]      out_mute;
    logic                auto_mute;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int pat = 0;
    int fidx = 0;

    // Reference model state.
    int m_fc, m_scnt;
    bit m_am;
    int m_att[NCH], m_patt[NCH];
    bit m_mute[NCH], m_pmute[NCH], m_pend[NCH], m_ts[NCH], m_prevneg[NCH];

    zc_vol_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .samples(samples),
        .req_wr(req_wr), .req_att(req_att), .req_mute(req_mute),
        .zc_disable(zc_disable), .automute_en(automute_en),
        .act_att(act_att), .act_mute(act_mute), .accept(accept),
        .out_mute(out_mute), .auto_mute(auto_mute)
    );

    always #2.5 clk = ~clk;

    function automatic int smp(input int ch);
        logic signed [SW-1:0] v;
        v = samples[ch*SW +: SW];
        return int'(v);
    endfunction

    // Behavioural reference, updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_fc = 0; m_scnt = 0; m_am = 0;
            for (int c = 0; c < NCH; c++) begin
                m_att[c] = 0; m_patt[c] = 0; m_mute[c] = 0; m_pmute[c] = 0;
                m_pend[c] = 0; m_ts[c] = 0; m_prevneg[c] = 0;
            end
        end else begin
            bit tk, sil;
            tk = frame_stb && (m_fc == 511);
            sil = 1;
            for (int c = 0; c < NCH; c++) if (smp(c) != 0 && smp(c) != -1) sil = 0;
            for (int c = 0; c < NCH; c++) begin
                bit zc;
                int s;
                s  = smp(c);
                zc = frame_stb && (s == 0 || ((s < 0) != m_prevneg[c]));
                if (req_wr[c]) begin
                    int a;
                    a = int'(req_att[c*AW +: AW]);
                    m_patt[c]  = (a > 85) ? 85 : a;
                    m_pmute[c] = req_mute[c];
                    if (zc_disable) begin
                        m_att[c] = m_patt[c]; m_mute[c] = m_pmute[c];
                        m_pend[c] = 0; m_ts[c] = 0;
                    end else begin
                        m_ts[c] = m_pend[c] && (m_ts[c] || tk);
                        m_pend[c] = 1;
                    end
                end else if (m_pend[c]) begin
                    if (zc_disable || zc || (tk && m_ts[c])) begin
                        m_att[c] = m_patt[c]; m_mute[c] = m_pmute[c];
                        m_pend[c] = 0; m_ts[c] = 0;
                    end else if (tk) m_ts[c] = 1;
                end
                if (frame_stb) m_prevneg[c] = (s < 0);
            end
            if (frame_stb) begin
                m_fc = (m_fc + 1) % 512;
                if (!sil) begin m_scnt = 0; m_am = 0; end
                else if (m_scnt == 511) m_am = 1;
                else m_scnt++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        bit am;
        am = m_am && automute_en;
        for (int c = 0; c < NCH; c++) begin
            chk("R1 R3 R4 R5 R9 act_att", int'(act_att[c*AW +: AW]), m_att[c]);
            chk("R6 act_mute", int'(act_mute[c]), int'(m_mute[c]));
            chk("R2 accept", int'(accept[c]), int'(m_pend[c]));
            chk("R7 out_mute", int'(out_mute[c]), int'(m_mute[c] || am));
        end
        chk("R7 R8 auto_mute", int'(auto_mute), int'(am));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        cycles++;
        if (rst_n) compare_all();
    endtask

    task automatic set_samples();
        for (int c = 0; c < NCH; c++) begin
            int v;
            case (pat)
                0: v = 1000 + c * 10;
                1: v = (fidx % 2) ? -300 - c : 300 + c;
                default: v = (c % 2) ? -1 : 0;
            endcase
            samples[c*SW +: SW] = SW'(v);
        end
    endtask

    task automatic frames(input int n);
        for (int k = 0; k < n; k++) begin
            set_samples();
            frame_stb = 1'b1;
            cyc();
            frame_stb = 1'b0;
            fidx++;
            for (int j = 0; j < 3; j++) cyc();
        end
    endtask

    task automatic write(input int ch, input int att, input bit mute);
        req_att[ch*AW +: AW] = AW'(att);
        req_mute[ch] = mute;
        req_wr[ch] = 1'b1;
        cyc();
        req_wr = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R10: reset state
        chk("R10 act_att", int'(act_att), 0);
        chk("R10 mute/accept", int'({act_mute, accept, out_mute}), 0);
        chk("R10 auto_mute", int'(auto_mute), 0);

        // R1/R2: no crossing on constant positive stream, then crossing
        pat = 0;
        frames(3);
        write(0, 10, 1'b0);
        frames(10);
        chk("R2 accept held", int'(accept[0]), 1);
        chk("R1 not applied", int'(act_att[0 +: AW]), 0);
        pat = 1;
        frames(2);
        chk("R1 applied at crossing", int'(act_att[0 +: AW]), 10);
        chk("R2 accept cleared", int'(accept[0]), 0);

        // R3/R4: timeout with replacement mid-wait
        pat = 0;
        write(1, 20, 1'b0);
        frames(300);
        write(1, 30, 1'b0);
        frames(300);
        chk("R4 still pending", int'(accept[1]), 1);
        frames(500);
        chk("R3 R4 timeout value", int'(act_att[1*AW +: AW]), 30);
        chk("R3 accept cleared", int'(accept[1]), 0);

        // R6: mute by timeout
        write(2, 0, 1'b1);
        frames(1100);
        chk("R6 mute applied", int'(out_mute[2]), 1);

        // R5/R9: bypass and saturation
        zc_disable = 1'b1;
        write(3, 40, 1'b0);
        chk("R5 immediate", int'(act_att[3*AW +: AW]), 40);
        write(4, 120, 1'b0);
        chk("R9 saturated", int'(act_att[4*AW +: AW]), 85);
        zc_disable = 1'b0;

        // Several channels together on alternating stream
        pat = 1;
        req_att = {7'd5, 7'd6, 7'd7, 7'd8, 7'd9, 7'd11};
        req_mute = 6'b100001;
        req_wr = '1;
        cyc();
        req_wr = '0;
        frames(2);
        chk("R1 R6 multi", int'(act_mute), 6'b100001);

        // R7/R8: silence auto-mute
        automute_en = 1'b1;
        pat = 2;
        frames(520);
        chk("R7 auto_mute set", int'(auto_mute), 1);
        chk("R7 all muted", int'(out_mute), 6'h3f);
        pat = 0;
        frames(1);
        chk("R8 released", int'(auto_mute), 0);
        automute_en = 1'b0;
        pat = 2;
        frames(520);
        chk("R8 disabled", int'(auto_mute), 0);
        frames(2);
        finish_run();
    end
endmodule